// File: doc/BRIEF.md
# Serial-In Latched Segment Driver Logic

This block is the digital core of a segment display driver. A serial bit stream is shifted into an N-stage register on each rising edge of a serial clock. An active-low load control makes a parallel holding register follow the shift register while it is low, and keeps the last value while it is high. A polarity input sets how the held bits reach the N segment outputs: either as stored or all inverted. A single backplane output always sits at the opposite level of the polarity input.

The last shift stage leaves the block on a serial output that changes only after a falling edge of the serial clock. Several blocks can therefore be chained, each block's serial input taken from the previous block's serial output. The serial clock, serial data and load control are asynchronous to the block clock. They pass through a synchronizer of configurable depth, and the block acts on the edges it detects after that.

Top module: `seg_serial_driver`

## Requirements
- R1: Synchronous active-low reset clears every shift stage, every held bit and the serial output to 0. While reset is asserted the polarity input still sets the segment and backplane levels: all segments 0 and backplane 0 with polarity 1, all segments 1 and backplane 1 with polarity 0.
- R2: Each rising edge of `ser_clk` moves the shift register one place: `ser_in` enters stage 0 and stage i moves to stage i+1. The first bit of an N-bit frame ends up in stage N-1, which drives `seg_out[N-1]`.
- R3: While `load_n` is low, the held bits follow the shift register, including bits shifted in during that time, within a few block clocks.
- R4: While `load_n` is high, the held bits keep their value, and shifting has no effect on `seg_out`.
- R5: `ser_out` carries shift stage N-1 and changes only after a detected falling edge of `ser_clk`. It keeps its value across the rising edge.
- R6: With `pol` = 1, `seg_out[i]` equals held bit i and `bp_out` is 0.
- R7: With `pol` = 0, `seg_out[i]` is the inverse of held bit i and `bp_out` is 1. Toggling `pol` does not alter the held bits.
- R8: Two blocks chained through `ser_out` to `ser_in` load a 2N-bit frame. The first bit lands in stage N-1 of the second block, and bit N lands in stage N-1 of the first block.
- R9: A `ser_clk` level held high for many block clocks causes exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples all serial controls |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_in | input | 1 | Serial data, sampled on the rising edge of ser_clk |
| load_n | input | 1 | Active-low transparent load control |
| pol | input | 1 | Output polarity: 1 shows the held bits as stored, 0 inverts them |
| ser_out | output | 1 | Cascade output, last shift stage, updated after the ser_clk falling edge |
| seg_out | output | N | Segment outputs |
| bp_out | output | 1 | Backplane output, opposite level to pol |

## Verification
A wrong shift stage appears on `ser_out` only after the bad bit has travelled to the last stage. That takes up to N serial clocks, or 2N when two blocks are chained, so the 2N-bit frame loads compare every segment of both blocks against the frame. A held bit that is wrong, or that drifts while `load_n` is high, shows on its segment at once and stays there until the next load. The bench therefore reads the segments after each load, after shifting while the load is held, and after each polarity toggle. Bad polarity logic appears in the same block clock as a backplane that matches `pol`, or as segments that do not all invert together.

// File: rtl/seg_drv_pkg.sv
// Package: shared types for the serial segment driver.
// Assumes nothing beyond IEEE 1800-2017.
package seg_drv_pkg;

    // Serial control inputs after synchronization, packed for the sync chain.
    typedef struct packed {
        logic sclk;
        logic sdat;
        logic ld_n;
    } ser_ctl_t;

    // Level that the synchronizer shows during reset: clock low, data 0, load inactive.
    localparam ser_ctl_t SER_CTL_IDLE = '{sclk: 1'b0, sdat: 1'b0, ld_n: 1'b1};

endpackage

// File: rtl/sdrv_sync.sv
// Module: multi-stage synchronizer for a packed group of asynchronous inputs.
// Assumes each input is stable long enough to be sampled in at least one clock.
module sdrv_sync
    import seg_drv_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  ser_ctl_t d,
    output ser_ctl_t q
);
    localparam int LAST = STAGES - 1;

    ser_ctl_t st [STAGES];

    // First stage: capture the raw asynchronous levels.
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= SER_CTL_IDLE;
        else        st[0] <= d;
    end

    // Further stages: give metastability time to resolve.
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) st[k] <= SER_CTL_IDLE;
            else        st[k] <= st[k-1];
        end
    end

    assign q = st[LAST];
endmodule

// File: rtl/sdrv_edge.sv
// Module: rising and falling edge detector for the synchronized serial clock.
// Assumes the input is already synchronous to clk.
module sdrv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev;

    // Remember the previous level to find transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/sdrv_shifter.sv
// Module: N-stage shift register with a cascade output updated on the falling edge.
// Assumes one-cycle rise/fall strobes that never arrive in the same clock.
module sdrv_shifter #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise,
    input  logic         fall,
    input  logic         sdat,
    output logic [N-1:0] stages,
    output logic         sout
);
    localparam int TOP = N - 1;

    // Advance the chain by one stage on each detected rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    stages <= '0;
        else if (rise) stages <= {stages[TOP-1:0], sdat};
    end

    // Present the last stage downstream only after the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    sout <= 1'b0;
        else if (fall) sout <= stages[TOP];
    end
endmodule

// File: rtl/sdrv_hold.sv
// Module: holding register, transparent while the active-low load is low.
// Assumes the load control is synchronous to clk.
module sdrv_hold #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    // Follow the shift register while load is low, keep the value otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (!ld_n) q <= d;
    end
endmodule

// File: rtl/seg_serial_driver.sv
// Module: serial-in, latched, polarity-controlled segment driver logic (top).
// Assumes ser_clk half periods span several clk cycles, and ser_in is stable
// around each rising edge of ser_clk. pol acts combinationally on the outputs.
module seg_serial_driver
    import seg_drv_pkg::*;
#(
    parameter int N           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk,
    input  logic         ser_in,
    input  logic         load_n,
    input  logic         pol,
    output logic         ser_out,
    output logic [N-1:0] seg_out,
    output logic         bp_out
);
    ser_ctl_t     raw_ctl;
    ser_ctl_t     sync_ctl;
    logic         sclk_s;
    logic         sdat_s;
    logic         ldn_s;
    logic         rise;
    logic         fall;
    logic [N-1:0] sr_q;
    logic [N-1:0] lat_q;

    // Group the asynchronous controls for one synchronizer.
    always_comb begin
        raw_ctl.sclk = ser_clk;
        raw_ctl.sdat = ser_in;
        raw_ctl.ld_n = load_n;
    end

    sdrv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_ctl),
        .q     (sync_ctl)
    );

    assign sclk_s = sync_ctl.sclk;
    assign sdat_s = sync_ctl.sdat;
    assign ldn_s  = sync_ctl.ld_n;

    sdrv_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sclk_s),
        .rise  (rise),
        .fall  (fall)
    );

    sdrv_shifter #(.N(N)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (rise),
        .fall   (fall),
        .sdat   (sdat_s),
        .stages (sr_q),
        .sout   (ser_out)
    );

    sdrv_hold #(.N(N)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_n  (ldn_s),
        .d     (sr_q),
        .q     (lat_q)
    );

    // Apply the global polarity to segments and drive the backplane opposite.
    always_comb begin
        seg_out = pol ? lat_q : ~lat_q;
        bp_out  = ~pol;
    end
endmodule

// File: rtl/seg_serial_driver_chk.sv
// Module: assertion checker for seg_serial_driver, attached by bind.
// Assumes it observes the synchronized strobes and register state of the top.
module seg_serial_driver_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rise,
    input logic         ldn_s,
    input logic [N-1:0] sr_q,
    input logic [N-1:0] lat_q,
    input logic         fall,
    input logic         ser_out,
    input logic [N-1:0] seg_out,
    input logic         bp_out
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sr_q == '0 && lat_q == '0 && ser_out == 1'b0));

    // R2
    shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(sr_q));

    // R3
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ldn_s |=> (lat_q == $past(sr_q)));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ldn_s |=> $stable(lat_q));

    // R5
    cascade_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(ser_out));

    // R7
    polarity_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_out ^ {N{bp_out}}) == lat_q);
endmodule

bind seg_serial_driver seg_serial_driver_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (rise),
    .ldn_s   (ldn_s),
    .sr_q    (sr_q),
    .lat_q   (lat_q),
    .fall    (fall),
    .ser_out (ser_out),
    .seg_out (seg_out),
    .bp_out  (bp_out)
);

// File: tb/sim_seg_serial_driver.sv
// Bench: two chained drivers with random frames and directed corner cases.
module sim_seg_serial_driver;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam int HALF       = 8;
    localparam int W          = 2 * N;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ser_clk;
    logic         ser_in;
    logic         load_n;
    logic         pol;
    logic         sout0, sout1;
    logic [N-1:0] seg0, seg1;
    logic         bp0, bp1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [W-1:0] chain;
    logic [W-1:0] held;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_serial_driver #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_in(ser_in),
        .load_n(load_n), .pol(pol), .ser_out(sout0), .seg_out(seg0), .bp_out(bp0)
    );
    seg_serial_driver #(.N(N)) u1 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_in(sout0),
        .load_n(load_n), .pol(pol), .ser_out(sout1), .seg_out(seg1), .bp_out(bp1)
    );

    function automatic logic [N-1:0] exp_seg(logic [N-1:0] h, logic p);
        return p ? h : ~h;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One serial bit: data set while clock low, rising then falling edge.
    task automatic shift_bit(logic b, int high_len);
        ser_in = b;
        wait_clk(HALF);
        ser_clk = 1'b1;
        wait_clk(high_len);
        ser_clk = 1'b0;
        wait_clk(HALF);
        chain = {chain[W-2:0], b};
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_clk(HALF);
        load_n = 1'b1;
        wait_clk(HALF);
        held = chain;
    endtask

    task automatic check_outputs(string req);
        check(req, {seg1, seg0}, {exp_seg(held[W-1:N], pol), exp_seg(held[N-1:0], pol)});
        check(req, {30'd0, bp1, bp0}, {30'd0, ~pol, ~pol});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        rst_n = 1'b0; ser_clk = 1'b0; ser_in = 1'b0; load_n = 1'b1; pol = 1'b1;
        chain = '0; held = '0;
        wait_clk(6);
        // R1: reset state, polarity still active during reset
        check("R1", {seg1, seg0}, '0);
        check("R1", {30'd0, bp1, bp0}, '0);
        check("R1", {30'd0, sout1, sout0}, '0);
        pol = 1'b0;
        wait_clk(1);
        check("R1", {seg1, seg0}, '1);
        check("R1", {30'd0, bp1, bp0}, {30'd0, 2'b11});
        pol = 1'b1;
        rst_n = 1'b1;
        wait_clk(4);

        // R2 R8: single marker bit travels to the far end of the second block
        shift_bit(1'b1, HALF);
        for (int i = 1; i < W; i++) shift_bit(1'b0, HALF);
        pulse_load();
        check("R2_R8", {seg1, seg0}, {1'b1, {(W-1){1'b0}}});
        check("R5", {31'd0, sout1}, {31'd0, chain[W-1]});

        // R8 R6 R7 R4: random frames through the chain
        for (int f = 0; f < 6; f++) begin
            logic [W-1:0] frame = $urandom();
            for (int i = W-1; i >= 0; i--) shift_bit(frame[i], HALF);
            // R5: cascade outputs hold the last stage of each block
            check("R5", {30'd0, sout1, sout0}, {30'd0, chain[W-1], chain[N-1]});
            pulse_load();
            check("R8", held, frame);
            pol = 1'b1;
            wait_clk(1);
            check_outputs("R6");
            pol = 1'b0;
            wait_clk(1);
            check_outputs("R7");
            pol = 1'b1;
            wait_clk(1);
            check_outputs("R7");
            // R4: shifting with load high must not touch segments
            for (int i = 0; i < 5; i++) shift_bit(1'($urandom()), HALF);
            check_outputs("R4");
        end

        // R3: transparent while load low, shifted bits appear directly
        load_n = 1'b0;
        wait_clk(HALF);
        held = chain;
        check_outputs("R3");
        shift_bit(1'b1, HALF);
        shift_bit(1'b0, HALF);
        held = chain;
        check_outputs("R3");
        load_n = 1'b1;
        wait_clk(HALF);

        // R9: long high level on ser_clk produces exactly one shift
        shift_bit(1'b1, 60);
        pulse_load();
        check_outputs("R9");

        // R7: inverted polarity after all-ones pattern
        for (int i = 0; i < W; i++) shift_bit(1'b1, HALF);
        pulse_load();
        pol = 1'b0;
        wait_clk(1);
        check_outputs("R7");
        pol = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule